// File: doc/BRIEF.md
# Word-Serial Pipelined Montgomery Multiplier

This block computes the Montgomery product X·Y·2^(−K) mod M for K-bit operands with an odd modulus M in the range 2^(K−1) < M < 2^K. Y and M are held word by word in an internal memory with one write port and one read port. The memory has E = ⌊K/W⌋ + 1 words of W bits, so it holds one spare word above the operand width for the top of the running sum. X is taken from a port when the operation starts and is consumed one bit at a time.

A chain of N processing elements, each handling one multiplier bit, is separated by pipeline registers. The first element is fed straight from the memory read register. Later elements receive the Y, M and sum words after they have passed through the element in front of them. One pass streams all E words through the chain and retires N multiplier bits. The last element writes the new running sum back into the memory while the next words are still being read. The running sum is kept in plain binary with a ripple carry inside each word. When all K bits have been used, a subtraction pass writes S − M into the result area. If that subtraction borrows, a copy pass writes S there instead.

The controller has nine states. IDLE waits for start. FEED issues the E reads of a multiply pass. DRAIN waits for the last word to leave the final element, then goes back to FEED or, after the final pass, to SUB. SUB issues the subtraction reads, and SUBEND retires the last subtraction word. PICK tests the final borrow and goes to COPY or to FIN. COPY issues the copy reads, and COPYEND retires the last copied word. FIN pulses done and returns to IDLE.

Top module: `montmul_pipe`

## Requirements
- R1: After done, result word j (bits j·W to j·W+W−1 of the product) is read at res_addr = j with one cycle of read latency. The result equals X·Y·2^(−K) mod M, is strictly below M, and its spare top word is zero.
- R2: After reset, busy and done are low. A start pulse sampled in IDLE raises busy in the next cycle. done is high for exactly one cycle, and busy is low in the cycle after done.
- R3: While busy is high, start pulses and changes on x_op have no effect on the operation in progress.
- R4: Every operation begins from a running sum of zero, so back-to-back operations on different operands each give their own correct result.
- R5: The result does not depend on the stage count N. This includes N values that do not divide K, where the elements beyond the remaining bit count pass the sum through unchanged on the final pass.
- R6: The boundary operands give correct results: X = 0, X = Y = 1, X = Y = M − 1, the smallest allowed odd M (2^(K−1) + 1) and the largest (2^K − 1).
- R7: Operand loads write Y word ld_y and M word ld_m at word index ld_addr (word j holds bits j·W upward, and the spare top word is loaded as zero). Loads are accepted only in IDLE. A load presented while busy changes neither the running operation nor the stored operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation; sampled in IDLE only |
| x_op | input | K | Multiplier X, captured when start is accepted |
| ld_we | input | 1 | Operand word write strobe, honoured in IDLE |
| ld_addr | input | AW | Word index of the operand write |
| ld_y | input | W | Y word to store |
| ld_m | input | W | M word to store |
| res_addr | input | AW | Word index of the result read, used in IDLE |
| res_data | output | W | Result word, one cycle after res_addr |
| busy | output | 1 | High from the cycle after start up to and including the done cycle |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that start and ld_we are clean synchronous pulses and that the loaded operands respect the modulus range, with Y below M. They also assume that the result area is read only while idle. Under those assumptions they check the busy/done handshake and that the host, sum and result writes never overlap. The stimulus draws an odd M with its top bit set, reduces X and Y modulo M, and always loads the spare word as zero. It issues pokes on start, x_op and the load port only in the middle of a run, well clear of done. The bench instantiates the block with N from 1 to 4 in parallel, so the same operands run through every chain depth.

// File: rtl/mm_pkg.sv
package mm_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FEED,
        ST_DRAIN,
        ST_SUB,
        ST_SUBEND,
        ST_PICK,
        ST_COPY,
        ST_COPYEND,
        ST_FIN
    } mm_state_t;

    typedef enum logic [1:0] {
        RK_MUL,
        RK_SUB,
        RK_COPY
    } mm_rdkind_t;

    // field order inside one memory word
    localparam int FLD_Y = 0;
    localparam int FLD_M = 1;
    localparam int FLD_S = 2;
    localparam int FLD_R = 3;
    localparam int NFLD  = 4;

endpackage

// File: rtl/mm_dpram.sv
module mm_dpram #(
    parameter int W     = 8,
    parameter int NF    = 4,
    parameter int DEPTH = 9,
    parameter int AW    = 4
) (
    input  logic            clk,
    input  logic [NF-1:0]   we,
    input  logic [AW-1:0]   waddr,
    input  logic [NF*W-1:0] wdata,
    input  logic [AW-1:0]   raddr,
    output logic [NF*W-1:0] rdata
);

    logic [W-1:0] rq [NF];

    for (genvar f = 0; f < NF; f++) begin : g_fld
        logic [W-1:0] mem [DEPTH];
        always_ff @(posedge clk) begin
            if (we[f]) begin
                mem[waddr] <= wdata[f*W +: W];
            end
            rq[f] <= mem[raddr];
        end
    end

    always_comb begin
        for (int f = 0; f < NF; f++) begin
            rdata[f*W +: W] = rq[f];
        end
    end

endmodule

// File: rtl/mm_pe.sv
module mm_pe #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         act,
    input  logic         xb,
    input  logic         in_v,
    input  logic         in_f,
    input  logic         in_l,
    input  logic [W-1:0] in_y,
    input  logic [W-1:0] in_m,
    input  logic [W-1:0] in_s,
    output logic         out_v,
    output logic         out_f,
    output logic         out_l,
    output logic [W-1:0] out_y,
    output logic [W-1:0] out_m,
    output logic [W-1:0] out_s
);

    localparam int SW = W + 2;

    logic         x_r, a_r, q_r, fo_r, tail_r;
    logic [1:0]   c_r;
    logic [W-1:0] prev_r, y_h, m_h;

    logic         x_u, a_u, q_u;
    logic [1:0]   cin;
    logic [SW-1:0] sum;
    logic [W-1:0] new_w;

    always_comb begin
        x_u   = in_f ? xb  : x_r;
        a_u   = in_f ? act : a_r;
        q_u   = in_f ? (in_s[0] ^ (x_u & in_y[0])) : q_r;
        cin   = in_f ? 2'b00 : c_r;
        sum   = SW'(in_s) + (x_u ? SW'(in_y) : '0) + (q_u ? SW'(in_m) : '0) + SW'(cin);
        new_w = a_u ? sum[W-1:0] : in_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_r    <= 1'b0;
            a_r    <= 1'b0;
            q_r    <= 1'b0;
            fo_r   <= 1'b0;
            tail_r <= 1'b0;
            c_r    <= '0;
            prev_r <= '0;
            y_h    <= '0;
            m_h    <= '0;
            out_v  <= 1'b0;
            out_f  <= 1'b0;
            out_l  <= 1'b0;
            out_y  <= '0;
            out_m  <= '0;
            out_s  <= '0;
        end else begin
            tail_r <= in_v & in_l;
            if (in_v) begin
                prev_r <= new_w;
                c_r    <= sum[W+1:W];
                y_h    <= in_y;
                m_h    <= in_m;
                fo_r   <= in_f;
                if (in_f) begin
                    x_r <= x_u;
                    a_r <= act;
                    q_r <= q_u;
                end
            end
            // emit the previous word once the low bit of the next one is known
            if (in_v && !in_f) begin
                out_v <= 1'b1;
                out_f <= fo_r;
                out_l <= 1'b0;
                out_y <= y_h;
                out_m <= m_h;
                out_s <= a_r ? {new_w[0], prev_r[W-1:1]} : prev_r;
            end else if (tail_r) begin
                out_v <= 1'b1;
                out_f <= fo_r;
                out_l <= 1'b1;
                out_y <= y_h;
                out_m <= m_h;
                out_s <= a_r ? {c_r[0], prev_r[W-1:1]} : prev_r;
            end else begin
                out_v <= 1'b0;
                out_f <= 1'b0;
                out_l <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/mm_seq.sv
module mm_seq
    import mm_pkg::*;
#(
    parameter int K  = 64,
    parameter int W  = 8,
    parameter int N  = 2,
    parameter int E  = 9,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [K-1:0]  x_op,
    input  logic          s_done,
    input  logic          borrow,
    output logic          busy,
    output logic          done,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    output logic          rd_first,
    output logic          rd_last,
    output mm_rdkind_t    rd_kind,
    output logic [N-1:0]  act,
    output logic [N-1:0]  xb,
    output logic          zero_s
);

    localparam int RW = $clog2(K + 1) + 1;

    mm_state_t     state, state_n;
    logic [AW-1:0] widx;
    logic [K-1:0]  xsh;
    logic [RW-1:0] rem;
    logic          firstp;
    logic          last_word;

    assign last_word = (widx == AW'(E - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:    if (start) state_n = ST_FEED;
            ST_FEED:    if (last_word) state_n = ST_DRAIN;
            ST_DRAIN:   if (s_done) state_n = (rem <= RW'(N)) ? ST_SUB : ST_FEED;
            ST_SUB:     if (last_word) state_n = ST_SUBEND;
            ST_SUBEND:  state_n = ST_PICK;
            ST_PICK:    state_n = borrow ? ST_COPY : ST_FIN;
            ST_COPY:    if (last_word) state_n = ST_COPYEND;
            ST_COPYEND: state_n = ST_FIN;
            ST_FIN:     state_n = ST_IDLE;
            default:    state_n = ST_IDLE;
        endcase
    end

    always_comb begin
        busy    = 1'b1;
        done    = 1'b0;
        rd_en   = 1'b0;
        rd_kind = RK_MUL;
        unique case (state)
            ST_IDLE:  busy = 1'b0;
            ST_FEED:  rd_en = 1'b1;
            ST_SUB:   begin rd_en = 1'b1; rd_kind = RK_SUB;  end
            ST_COPY:  begin rd_en = 1'b1; rd_kind = RK_COPY; end
            ST_FIN:   done = 1'b1;
            default:  ;
        endcase
        rd_addr  = widx;
        rd_first = (widx == '0);
        rd_last  = last_word;
        zero_s   = firstp;
        xb       = xsh[N-1:0];
        for (int p = 0; p < N; p++) begin
            act[p] = (RW'(p) < rem);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            widx   <= '0;
            xsh    <= '0;
            rem    <= '0;
            firstp <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    widx <= '0;
                    if (start) begin
                        xsh    <= x_op;
                        rem    <= RW'(K);
                        firstp <= 1'b1;
                    end
                end
                ST_FEED, ST_SUB, ST_COPY: widx <= widx + 1'b1;
                ST_DRAIN: begin
                    widx <= '0;
                    if (s_done && rem > RW'(N)) begin
                        xsh    <= xsh >> N;
                        rem    <= rem - RW'(N);
                        firstp <= 1'b0;
                    end
                end
                default: widx <= '0;
            endcase
        end
    end

endmodule

// File: rtl/montmul_pipe.sv
module montmul_pipe
    import mm_pkg::*;
#(
    parameter int K = 64,
    parameter int W = 8,
    parameter int N = 2,
    localparam int E  = (K + W) / W,
    localparam int AW = $clog2(E)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [K-1:0]  x_op,
    input  logic          ld_we,
    input  logic [AW-1:0] ld_addr,
    input  logic [W-1:0]  ld_y,
    input  logic [W-1:0]  ld_m,
    input  logic [AW-1:0] res_addr,
    output logic [W-1:0]  res_data,
    output logic          busy,
    output logic          done
);

    logic          rd_en, rd_first, rd_last, zero_s, s_done;
    logic [AW-1:0] seq_addr, raddr, waddr, wcnt, s_waddr, raddr_d;
    mm_rdkind_t    rd_kind, rk;
    logic [N-1:0]  act, xb;
    logic          rv, rf, rl, borrow_r, bin;
    logic [NFLD-1:0]   we;
    logic [NFLD*W-1:0] wdata, rdata;
    logic [W-1:0]  f_y, f_m, f_s, r_wdata;
    logic [W:0]    diff;
    logic          host_wr, s_wr, r_wr;

    logic         sv [N+1];
    logic         sf [N+1];
    logic         sl [N+1];
    logic [W-1:0] sy [N+1];
    logic [W-1:0] sm [N+1];
    logic [W-1:0] ss [N+1];

    mm_seq #(.K(K), .W(W), .N(N), .E(E), .AW(AW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .x_op(x_op),
        .s_done(s_done), .borrow(borrow_r), .busy(busy), .done(done),
        .rd_en(rd_en), .rd_addr(seq_addr), .rd_first(rd_first),
        .rd_last(rd_last), .rd_kind(rd_kind), .act(act), .xb(xb),
        .zero_s(zero_s)
    );

    assign raddr = busy ? seq_addr : res_addr;

    mm_dpram #(.W(W), .NF(NFLD), .DEPTH(E), .AW(AW)) u_ram (
        .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
        .raddr(raddr), .rdata(rdata)
    );

    assign f_y      = rdata[FLD_Y*W +: W];
    assign f_m      = rdata[FLD_M*W +: W];
    assign f_s      = rdata[FLD_S*W +: W];
    assign res_data = rdata[FLD_R*W +: W];

    // read-side flags aligned with the registered memory output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rv      <= 1'b0;
            rf      <= 1'b0;
            rl      <= 1'b0;
            rk      <= RK_MUL;
            raddr_d <= '0;
        end else begin
            rv      <= rd_en;
            rf      <= rd_first;
            rl      <= rd_last;
            rk      <= rd_kind;
            raddr_d <= seq_addr;
        end
    end

    assign sv[0] = rv && (rk == RK_MUL);
    assign sf[0] = rf;
    assign sl[0] = rl;
    assign sy[0] = f_y;
    assign sm[0] = f_m;
    assign ss[0] = zero_s ? '0 : f_s;

    for (genvar p = 0; p < N; p++) begin : g_pe
        mm_pe #(.W(W)) u_pe (
            .clk(clk), .rst_n(rst_n), .act(act[p]), .xb(xb[p]),
            .in_v(sv[p]), .in_f(sf[p]), .in_l(sl[p]),
            .in_y(sy[p]), .in_m(sm[p]), .in_s(ss[p]),
            .out_v(sv[p+1]), .out_f(sf[p+1]), .out_l(sl[p+1]),
            .out_y(sy[p+1]), .out_m(sm[p+1]), .out_s(ss[p+1])
        );
    end

    assign s_done  = sv[N] && sl[N];
    assign s_waddr = sf[N] ? '0 : wcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     wcnt <= '0;
        else if (sv[N]) wcnt <= s_waddr + 1'b1;
    end

    // final reduction: S - M, or S copied when that borrows
    assign bin  = rf ? 1'b0 : borrow_r;
    assign diff = {1'b0, f_s} - {1'b0, f_m} - {{W{1'b0}}, bin};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     borrow_r <= 1'b0;
        else if (rv && rk == RK_SUB)    borrow_r <= diff[W];
    end

    assign r_wdata = (rk == RK_SUB) ? diff[W-1:0] : f_s;
    assign host_wr = ld_we && !busy;
    assign s_wr    = sv[N];
    assign r_wr    = rv && (rk != RK_MUL);

    always_comb begin
        we          = '0;
        we[FLD_Y]   = host_wr;
        we[FLD_M]   = host_wr;
        we[FLD_S]   = s_wr;
        we[FLD_R]   = r_wr;
        waddr       = host_wr ? ld_addr : (s_wr ? s_waddr : raddr_d);
        wdata                = '0;
        wdata[FLD_Y*W +: W]  = ld_y;
        wdata[FLD_M*W +: W]  = ld_m;
        wdata[FLD_S*W +: W]  = ss[N];
        wdata[FLD_R*W +: W]  = r_wdata;
    end

endmodule

// File: rtl/montmul_chk.sv
module montmul_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic host_wr,
    input logic s_wr,
    input logic r_wr
);

    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    assert_busy_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    assert_no_host_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !host_wr);

    assert_single_writer_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({host_wr, s_wr, r_wr}));

    assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!s_wr && !r_wr));

endmodule

bind montmul_pipe montmul_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .host_wr(host_wr), .s_wr(s_wr), .r_wr(r_wr)
);

// File: tb/montmul_pipe_tb.sv
module montmul_pipe_tb_top;

    localparam int K  = 64;
    localparam int W  = 8;
    localparam int E  = (K + W) / W;
    localparam int AW = $clog2(E);
    localparam int NI = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [K-1:0]  x_op = '0;
    logic          ld_we = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [W-1:0]  ld_y = '0;
    logic [W-1:0]  ld_m = '0;
    logic [AW-1:0] res_addr = '0;
    logic [W-1:0]  res_data [NI];
    logic [NI-1:0] busy, done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    for (genvar g = 0; g < NI; g++) begin : g_n
        montmul_pipe #(.K(K), .W(W), .N(g + 1)) dut_i (
            .clk(clk), .rst_n(rst_n), .start(start), .x_op(x_op),
            .ld_we(ld_we), .ld_addr(ld_addr), .ld_y(ld_y), .ld_m(ld_m),
            .res_addr(res_addr), .res_data(res_data[g]),
            .busy(busy[g]), .done(done[g])
        );
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired at cycle %0d", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic load_ops(input logic [K-1:0] y, input logic [K-1:0] m);
        logic [E*W-1:0] ye, me;
        ye = {{(E*W-K){1'b0}}, y};
        me = {{(E*W-K){1'b0}}, m};
        for (int j = 0; j < E; j++) begin
            @(negedge clk);
            ld_we   = 1'b1;
            ld_addr = AW'(j);
            ld_y    = ye[j*W +: W];
            ld_m    = me[j*W +: W];
        end
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic run_op(input logic [K-1:0] x, input bit poke_start, input bit poke_load);
        logic [NI-1:0] seen, pend;
        int n;
        @(negedge clk);
        x_op  = x;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        x_op  = ~x;
        for (int g = 0; g < NI; g++)
            chk(busy[g] == 1'b1, "R2 busy after start", 128'(busy[g]), 128'd1);
        seen = '0;
        pend = '0;
        n = 0;
        while (seen != '1) begin
            @(negedge clk);
            n = n + 1;
            if (poke_start && n == 5) begin start = 1'b1; x_op = x ^ 64'h5a5a; end
            if (n == 6) start = 1'b0;
            if (poke_load && n >= 7 && n < 7 + E) begin
                ld_we = 1'b1; ld_addr = AW'(n - 7); ld_y = 8'hff; ld_m = 8'h11;
            end
            if (n == 7 + E) ld_we = 1'b0;
            for (int g = 0; g < NI; g++) begin
                if (pend[g]) begin
                    chk(!done[g] && !busy[g], "R2 done single pulse then idle",
                        128'({done[g], busy[g]}), 128'd0);
                    pend[g] = 1'b0;
                end
                if (done[g] && !seen[g]) begin
                    seen[g] = 1'b1;
                    pend[g] = 1'b1;
                end
            end
        end
        @(negedge clk);
        for (int g = 0; g < NI; g++) begin
            if (pend[g])
                chk(!done[g] && !busy[g], "R2 done single pulse then idle",
                    128'({done[g], busy[g]}), 128'd0);
        end
    endtask

    task automatic check_res(input logic [K-1:0] x, input logic [K-1:0] y,
                             input logic [K-1:0] m, input string req);
        logic [E*W-1:0] acc [NI];
        logic [127:0] r, lhs, rhs;
        for (int j = 0; j < E; j++) begin
            @(negedge clk);
            res_addr = AW'(j);
            @(negedge clk);
            for (int g = 0; g < NI; g++) acc[g][j*W +: W] = res_data[g];
        end
        rhs = (128'(x) * 128'(y)) % 128'(m);
        for (int g = 0; g < NI; g++) begin
            r   = 128'(acc[g]);
            lhs = (r << K) % 128'(m);
            chk(r < 128'(m), $sformatf("R1 R5 %s N=%0d below modulus", req, g + 1), r, 128'(m));
            chk(lhs == rhs, $sformatf("R1 R5 %s N=%0d congruence", req, g + 1), lhs, rhs);
        end
    endtask

    task automatic do_case(input logic [K-1:0] x, input logic [K-1:0] y,
                           input logic [K-1:0] m, input string req);
        load_ops(y, m);
        run_op(x, 1'b0, 1'b0);
        check_res(x, y, m, req);
    endtask

    function automatic logic [K-1:0] rand_mod();
        logic [K-1:0] v;
        v = {$urandom(), $urandom()};
        v[K-1] = 1'b1;
        v[0]   = 1'b1;
        return v;
    endfunction

    initial begin
        logic [K-1:0] m, x, y;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int g = 0; g < NI; g++)
            chk(!busy[g] && !done[g], "R2 reset state", 128'({busy[g], done[g]}), 128'd0);

        // R6 boundary operands
        m = rand_mod();
        do_case('0, m - 1, m, "R6 x zero");
        do_case(64'd1, 64'd1, m, "R6 one by one");
        do_case(m - 1, m - 1, m, "R6 m-1 squared");
        m = {1'b1, {(K-2){1'b0}}, 1'b1};
        do_case(m - 1, m - 3, m, "R6 smallest modulus");
        m = '1;
        do_case(m - 2, m - 1, m, "R6 largest modulus");

        // R4 back-to-back random operations with fresh operands
        for (int t = 0; t < 8; t++) begin
            m = rand_mod();
            x = {$urandom(), $urandom()} % m;
            y = {$urandom(), $urandom()} % m;
            do_case(x, y, m, "R4 random");
        end

        // R3 start and x_op changes while busy are ignored
        m = rand_mod();
        x = {$urandom(), $urandom()} % m;
        y = {$urandom(), $urandom()} % m;
        load_ops(y, m);
        run_op(x, 1'b1, 1'b0);
        check_res(x, y, m, "R3 start poke");

        // R7 loads while busy are ignored: result and stored operands intact
        m = rand_mod();
        x = {$urandom(), $urandom()} % m;
        y = {$urandom(), $urandom()} % m;
        load_ops(y, m);
        run_op(x, 1'b0, 1'b1);
        check_res(x, y, m, "R7 load poke");
        x = {$urandom(), $urandom()} % m;
        run_op(x, 1'b0, 1'b0);
        check_res(x, y, m, "R7 operands kept");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule